// File: doc/BRIEF.md
# Four-Source Interrupt Controller

This block collects interrupt events from four sources and raises one request to the processor core. The four sources are:

- a selectable edge on bit 0 of an 8-bit input port;
- a strobe when a timer overflows;
- a strobe when an analog conversion completes;
- a change on the upper nibble of the same port.

It holds one byte that carries the three event flags, the four source enables and the global enable. It also holds a second byte whose bit 1 carries the conversion-complete flag. Software reads and writes both bytes through a small register port.

The pins pass through a two-flop synchronizer before any detection. The synchronized port value is also returned to the core as its port read data. When the core reads the port, it also refreshes the copy of the upper nibble that the change detector compares against.

The core answers a request by pulsing a take strobe, which drops the global enable so that no second interrupt nests inside the first. The vector address is presented on a constant output. The return strobe raises the global enable again.

A power-on reset clears everything. A warm reset (watchdog or master clear) clears everything except the port-change flag.

Top module: `intc4_ctrl`

## Requirements
- R1: While rst_ni is low, all state clears. After release, address 0 reads 0x00, address 1 reads 0x00 and irq_req_o is 0.
- R2: The byte at address 0 is laid out as follows: bit0 port-change flag, bit1 pin-edge flag, bit2 timer flag, bit3 port-change enable, bit4 pin-edge enable, bit5 timer enable, bit6 conversion enable, bit7 global enable. A write to address 0 loads all eight bits, and a read returns them.
- R3: With edge_sel_i = 0, a falling edge on port bit 0 sets bit1. With edge_sel_i = 1, a rising edge sets it. After a pin change, bit1 reads 1 after the third rising clock edge and not after the second.
- R4: Bit0 is set on any clock in which synchronized port bits 7:4 differ from the copy captured on the last cycle with port_rd_i high. Port bits 3:0 have no effect on it.
- R5: A tmr_ovf_i pulse sets bit2 on the next clock edge.
- R6: An adc_done_i pulse sets bit 1 of address 1. The bit stays set until software writes 0 to it, and the other bits of address 1 read 0.
- R7: irq_req_o is 1 exactly when the global enable is 1 and some source has both its flag and its enable set. Flags are set even when their enables are 0.
- R8: A hardware set of a flag in the same cycle as a software write of 0 to that flag leaves the flag at 1.
- R9: irq_take_i clears the global enable. irq_ret_i sets it. Take has priority over return, and both have priority over a register write.
- R10: warm_rst_i clears every bit of both bytes except bit0 of address 0, which keeps its value.
- R11: vec_o always equals 0x004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| warm_rst_i | input | 1 | Synchronous watchdog or master-clear reset |
| port_i | input | 8 | Asynchronous port pins |
| edge_sel_i | input | 1 | Pin edge select: 0 falling, 1 rising |
| port_rd_i | input | 1 | Core reads the port; refreshes the change copy |
| port_o | output | 8 | Synchronized port value |
| tmr_ovf_i | input | 1 | Timer overflow strobe |
| adc_done_i | input | 1 | Conversion complete strobe |
| reg_addr_i | input | 1 | 0 selects flag/enable byte, 1 selects conversion byte |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| irq_take_i | input | 1 | Core takes the interrupt |
| irq_ret_i | input | 1 | Core returns from the interrupt |
| irq_req_o | output | 1 | Interrupt request |
| vec_o | output | 10 | Interrupt vector address |

## Verification
The bench goes after the moments when two things happen in one cycle, and after the places where the detectors can go wrong.

- **Hardware set against a software clear.** If the clear wins, the timer or conversion event disappears.
- **Take and return together, or with a write.** A design with the wrong priority re-enables interrupts inside a handler.
- **Port-change flag held while the copy is stale.** A design that detects only a transition instead of a mismatch lets software clear the flag while the port still differs from the copy.
- **Pin and edge timing.** A synchronizer with the wrong depth shows the pin-edge flag one cycle early or late. A wrong edge polarity sets the flag on the opposite transition.
- **Lower port nibble.** The bench toggles port bits 3:0 to catch a change detector that also watches them.
- **Warm reset.** The bench checks that the port-change flag survives while every enable drops.

// File: rtl/intc4_pkg.sv
package intc4_pkg;
  typedef logic [7:0] byte_t;

  localparam int unsigned B_CHG_F = 0;
  localparam int unsigned B_EXT_F = 1;
  localparam int unsigned B_TMR_F = 2;
  localparam int unsigned B_CHG_E = 3;
  localparam int unsigned B_EXT_E = 4;
  localparam int unsigned B_TMR_E = 5;
  localparam int unsigned B_ADC_E = 6;
  localparam int unsigned B_GIE   = 7;
  localparam int unsigned B_ADC_F = 1;

  localparam int unsigned N_FLAG = 3;
  localparam int unsigned N_SRC  = 4;
endpackage

// File: rtl/intc4_sync.sv
module intc4_sync #(
  parameter int unsigned W = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else if (s == 0) stg_q[s] <= d_i;
        else stg_q[s] <= stg_q[s-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/intc4_detect.sv
module intc4_detect #(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned CHG_W  = 4,
  localparam int unsigned CHG_LO = PORT_W - CHG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] sync_i,
  input  logic              edge_sel_i,
  input  logic              port_rd_i,
  output logic              ext_evt_o,
  output logic              chg_evt_o
);
  logic             pin_prev_q;
  logic [CHG_W-1:0] ref_q;
  logic [CHG_W-1:0] hi_nib;

  assign hi_nib = sync_i[PORT_W-1:CHG_LO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_prev_q <= 1'b0;
      ref_q      <= '0;
    end else begin
      pin_prev_q <= sync_i[0];
      if (port_rd_i) ref_q <= hi_nib;
    end
  end

  always_comb begin
    if (edge_sel_i) ext_evt_o = sync_i[0] & ~pin_prev_q;
    else            ext_evt_o = ~sync_i[0] & pin_prev_q;
  end

  assign chg_evt_o = (hi_nib != ref_q);

  p_ref_refresh_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_rd_i |=> (ref_q == $past(hi_nib)));
  p_ref_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_rd_i |=> $stable(ref_q));
endmodule

// File: rtl/intc4_regs.sv
module intc4_regs
  import intc4_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  warm_rst_i,
  input  logic  chg_evt_i,
  input  logic  ext_evt_i,
  input  logic  tmr_ovf_i,
  input  logic  adc_done_i,
  input  logic  reg_addr_i,
  input  logic  reg_wr_i,
  input  byte_t reg_wdata_i,
  input  logic  irq_take_i,
  input  logic  irq_ret_i,
  output byte_t reg_rdata_o,
  output logic  irq_req_o
);
  logic [N_FLAG-1:0] flag_q, flag_d, hw_set;
  logic [N_SRC-1:0]  en_q, en_d, pend;
  logic              gie_q, gie_d;
  logic              adc_q, adc_d;
  logic              wr_main, wr_adc;

  assign wr_main = reg_wr_i & ~reg_addr_i;
  assign wr_adc  = reg_wr_i & reg_addr_i;
  assign hw_set  = {tmr_ovf_i, ext_evt_i, chg_evt_i};

  generate
    for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
      always_comb begin
        if (warm_rst_i) flag_d[i] = (i == B_CHG_F) ? flag_q[i] : 1'b0;
        else            flag_d[i] = hw_set[i] | (wr_main ? reg_wdata_i[i] : flag_q[i]);
      end
    end
  endgenerate

  always_comb begin
    en_d  = en_q;
    gie_d = gie_q;
    adc_d = adc_q;
    if (warm_rst_i) begin
      en_d  = '0;
      gie_d = 1'b0;
      adc_d = 1'b0;
    end else begin
      if (wr_main) begin
        en_d  = reg_wdata_i[B_ADC_E:B_CHG_E];
        gie_d = reg_wdata_i[B_GIE];
      end
      if (irq_take_i)     gie_d = 1'b0;
      else if (irq_ret_i) gie_d = 1'b1;
      adc_d = adc_done_i | (wr_adc ? reg_wdata_i[B_ADC_F] : adc_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      en_q   <= '0;
      gie_q  <= 1'b0;
      adc_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
      gie_q  <= gie_d;
      adc_q  <= adc_d;
    end
  end

  // source order matches enable order: chg, ext, tmr, adc
  assign pend      = {adc_q, flag_q} & en_q;
  assign irq_req_o = gie_q & (|pend);

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i) reg_rdata_o[B_ADC_F] = adc_q;
    else            reg_rdata_o = {gie_q, en_q, flag_q};
  end

  p_tmr_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_ovf_i && !warm_rst_i) |=> flag_q[B_TMR_F]);
  p_adc_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_done_i && !warm_rst_i) |=> adc_q);
  p_adc_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_q && !wr_adc && !warm_rst_i) |=> adc_q);
  p_hw_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_main && ext_evt_i && !warm_rst_i) |=> flag_q[B_EXT_F]);
  p_take_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_i |=> !gie_q);
  p_ret_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ret_i && !irq_take_i && !warm_rst_i) |=> gie_q);
  p_warm_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_i |=> (flag_q[B_CHG_F] == $past(flag_q[B_CHG_F])) && en_q == '0 && !gie_q);
  p_req_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_rst_i || irq_take_i) |=> !irq_req_o);
endmodule

// File: rtl/intc4_ctrl.sv
module intc4_ctrl
  import intc4_pkg::*;
#(
  parameter int unsigned PORT_W   = 8,
  parameter int unsigned CHG_W    = 4,
  parameter int unsigned VEC_W    = 10,
  parameter logic [VEC_W-1:0] VEC_ADDR = 10'h004
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              edge_sel_i,
  input  logic              port_rd_i,
  output logic [PORT_W-1:0] port_o,
  input  logic              tmr_ovf_i,
  input  logic              adc_done_i,
  input  logic              reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              irq_take_i,
  input  logic              irq_ret_i,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [PORT_W-1:0] port_s;
  logic              ext_evt, chg_evt;

  intc4_sync #(.W(PORT_W), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (port_i),
    .q_o   (port_s)
  );

  intc4_detect #(.PORT_W(PORT_W), .CHG_W(CHG_W)) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (port_s),
    .edge_sel_i(edge_sel_i),
    .port_rd_i (port_rd_i),
    .ext_evt_o (ext_evt),
    .chg_evt_o (chg_evt)
  );

  intc4_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .warm_rst_i (warm_rst_i),
    .chg_evt_i  (chg_evt),
    .ext_evt_i  (ext_evt),
    .tmr_ovf_i  (tmr_ovf_i),
    .adc_done_i (adc_done_i),
    .reg_addr_i (reg_addr_i),
    .reg_wr_i   (reg_wr_i),
    .reg_wdata_i(reg_wdata_i),
    .irq_take_i (irq_take_i),
    .irq_ret_i  (irq_ret_i),
    .reg_rdata_o(reg_rdata_o),
    .irq_req_o  (irq_req_o)
  );

  assign port_o = port_s;
  assign vec_o  = VEC_ADDR;

  p_chg_lo_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_s[PORT_W-1:PORT_W-CHG_W] == $past(port_s[PORT_W-1:PORT_W-CHG_W]) && $past(!port_rd_i)
     && $past(!chg_evt)) |-> !chg_evt);
endmodule

// File: tb/intc4_ctrl_tb.sv
`timescale 1ns/1ps
module intc4_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       warm_rst_i = 1'b0;
  logic [7:0] port_i = 8'h00;
  logic       edge_sel_i = 1'b0;
  logic       port_rd_i = 1'b0;
  logic [7:0] port_o;
  logic       tmr_ovf_i = 1'b0;
  logic       adc_done_i = 1'b0;
  logic       reg_addr_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       irq_take_i = 1'b0;
  logic       irq_ret_i = 1'b0;
  logic       irq_req_o;
  logic [9:0] vec_o;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  intc4_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .warm_rst_i(warm_rst_i), .port_i(port_i),
    .edge_sel_i(edge_sel_i), .port_rd_i(port_rd_i), .port_o(port_o),
    .tmr_ovf_i(tmr_ovf_i), .adc_done_i(adc_done_i), .reg_addr_i(reg_addr_i),
    .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .irq_take_i(irq_take_i), .irq_ret_i(irq_ret_i), .irq_req_o(irq_req_o), .vec_o(vec_o)
  );

  // behavioural reference: pin history as a queue, register as named fields
  bit [7:0] m_pipe[$];
  bit       m_last0;
  bit [3:0] m_copy;
  bit       m_cf, m_ef, m_tf, m_ce, m_ee, m_te, m_ae, m_ge, m_adc;

  function automatic bit [7:0] m_synced();
    return m_pipe[1];
  endfunction

  function automatic bit [7:0] m_read(bit a);
    if (a) return {6'd0, m_adc, 1'b0};
    return {m_ge, m_ae, m_te, m_ee, m_ce, m_tf, m_ef, m_cf};
  endfunction

  function automatic bit m_req();
    return m_ge && ((m_cf && m_ce) || (m_ef && m_ee) || (m_tf && m_te) || (m_adc && m_ae));
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pipe = {8'h00, 8'h00};
      m_last0 = 0; m_copy = 0;
      {m_cf, m_ef, m_tf, m_ce, m_ee, m_te, m_ae, m_ge, m_adc} = '0;
    end else begin
      bit [7:0] s;
      bit pin_ev, chg_ev, wm, wa;
      s = m_synced();
      pin_ev = edge_sel_i ? (s[0] && !m_last0) : (!s[0] && m_last0);
      chg_ev = (s[7:4] != m_copy);
      wm = reg_wr_i && !reg_addr_i;
      wa = reg_wr_i && reg_addr_i;
      if (warm_rst_i) begin
        {m_ef, m_tf, m_ce, m_ee, m_te, m_ae, m_ge, m_adc} = '0;
      end else begin
        if (wm) begin
          {m_ge, m_ae, m_te, m_ee, m_ce, m_tf, m_ef, m_cf} = reg_wdata_i;
        end
        if (chg_ev) m_cf = 1;
        if (pin_ev) m_ef = 1;
        if (tmr_ovf_i) m_tf = 1;
        if (irq_take_i) m_ge = 0;
        else if (irq_ret_i) m_ge = 1;
        if (wa) m_adc = reg_wdata_i[1];
        if (adc_done_i) m_adc = 1;
      end
      m_last0 = s[0];
      if (port_rd_i) m_copy = s[7:4];
      m_pipe.push_front(port_i);
      void'(m_pipe.pop_back());
    end
  end

  task automatic chk(input bit [15:0] act, input bit [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (cmp_on && rst_ni) begin
      chk({8'd0, reg_rdata_o}, {8'd0, m_read(reg_addr_i)}, "R2 model read");
      chk({15'd0, irq_req_o}, {15'd0, m_req()}, "R7 model request");
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic probe(input bit a, input bit [7:0] exp, input string tag);
    reg_addr_i = a;
    @(negedge clk_i);
    chk({8'd0, reg_rdata_o}, {8'd0, exp}, tag);
    step();
  endtask

  task automatic wr(input bit a, input bit [7:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1;
    step();
    reg_wr_i = 0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #12 step(2);
    @(negedge clk_i);
    chk({8'd0, reg_rdata_o}, 16'h0000, "R1 reset main byte");
    chk({15'd0, irq_req_o}, 16'h0000, "R1 reset request");
    rst_ni = 1;
    step();
    cmp_on = 1;
    probe(1, 8'h00, "R1 reset conversion byte");
    chk({6'd0, vec_o}, 16'h0004, "R11 vector");

    wr(0, 8'h78);
    probe(0, 8'h78, "R2 write/read layout");
    wr(0, 8'h00);

    // R3 falling edge, sel=0
    edge_sel_i = 0; port_i = 8'h01; step(4);
    probe(0, 8'h00, "R3 rising ignored when sel=0");
    port_i = 8'h00; step(2);
    reg_addr_i = 0; @(negedge clk_i);
    chk({8'd0, reg_rdata_o}, 16'h0000, "R3 not yet after two edges");
    step();
    probe(0, 8'h02, "R3 falling sets bit1 after third edge");
    wr(0, 8'h00);
    edge_sel_i = 1; port_i = 8'h01; step(3);
    probe(0, 8'h02, "R3 rising sets bit1 when sel=1");
    wr(0, 8'h00);

    // R4 port change
    port_i = 8'h0F; step(4);
    probe(0, 8'h00, "R4 lower nibble ignored");
    port_i = 8'h5F; step(3);
    probe(0, 8'h01, "R4 upper nibble change");
    wr(0, 8'h00);
    probe(0, 8'h01, "R4 stale copy keeps flag");
    port_rd_i = 1; step(); port_rd_i = 0;
    chk({8'd0, port_o}, 16'h005F, "R4 synchronized port value");
    wr(0, 8'h00);
    probe(0, 8'h00, "R4 cleared after copy refresh");

    // R5, R8 timer
    tmr_ovf_i = 1; step(); tmr_ovf_i = 0;
    probe(0, 8'h04, "R5 timer sets bit2");
    tmr_ovf_i = 1; wr(0, 8'h00); tmr_ovf_i = 0;
    probe(0, 8'h04, "R8 hardware set beats clear");

    // R6 conversion
    adc_done_i = 1; step(); adc_done_i = 0;
    step(5);
    probe(1, 8'h02, "R6 conversion flag sticky");
    wr(1, 8'hFD);
    probe(1, 8'h00, "R6 software clear");

    // R7 request gating
    adc_done_i = 1; step(); adc_done_i = 0;
    @(negedge clk_i);
    chk({15'd0, irq_req_o}, 16'h0000, "R7 flags without enables");
    step();
    wr(0, 8'hC4);
    @(negedge clk_i);
    chk({15'd0, irq_req_o}, 16'h0001, "R7 conversion source request");
    step();
    wr(0, 8'hA4);
    @(negedge clk_i);
    chk({15'd0, irq_req_o}, 16'h0001, "R7 timer source request");
    step();

    // R9 take/return
    irq_take_i = 1; irq_ret_i = 1; step(); irq_take_i = 0; irq_ret_i = 0;
    @(negedge clk_i);
    chk({15'd0, irq_req_o}, 16'h0000, "R9 take beats return");
    step();
    irq_ret_i = 1; reg_wdata_i = 8'h24; reg_addr_i = 0; reg_wr_i = 1; step();
    irq_ret_i = 0; reg_wr_i = 0;
    probe(0, 8'hA4, "R9 return beats write");

    // R10 warm reset
    port_i = 8'hA0; step(3);
    warm_rst_i = 1; step(); warm_rst_i = 0;
    probe(0, 8'h01, "R10 warm keeps port-change flag");
    probe(1, 8'h00, "R10 warm clears conversion flag");

    // random phase against the reference
    for (int i = 0; i < 3000; i++) begin
      port_i     = ($urandom_range(0, 7) == 0) ? 8'($urandom) : port_i;
      edge_sel_i = ($urandom_range(0, 50) == 0) ? ~edge_sel_i : edge_sel_i;
      port_rd_i  = ($urandom_range(0, 5) == 0);
      tmr_ovf_i  = ($urandom_range(0, 9) == 0);
      adc_done_i = ($urandom_range(0, 11) == 0);
      reg_addr_i = 1'($urandom);
      reg_wr_i   = ($urandom_range(0, 6) == 0);
      reg_wdata_i = 8'($urandom);
      irq_take_i = irq_req_o && ($urandom_range(0, 2) == 0);
      irq_ret_i  = ($urandom_range(0, 12) == 0);
      warm_rst_i = ($urandom_range(0, 200) == 0);
      step();
    end
    {port_rd_i, tmr_ovf_i, adc_done_i, reg_wr_i, irq_take_i, irq_ret_i, warm_rst_i} = '0;
    step(2);
    chk({6'd0, vec_o}, 16'h0004, "R11 vector after traffic");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule